// File: doc/BRIEF.md
# Event Identifier Match Sequencer

This block holds a queue of 36-bit event identifiers that arrive from the trigger system. It takes them one at a time and confirms that every enabled readout channel has returned the same identifier. For each identifier it broadcasts a numbered request to the channels. While matching is incomplete it repeats the request after a programmable wait. Each channel's answer carries a channel number, the request number it answers and an event identifier. A valid answer sets that channel's matched bit. Once every enabled channel is matched, the block retires the identifier, bumps the request number and takes the next one from the queue.

Software can freeze the sequencer with a halt level. Answers are still recorded while it is frozen, but no request is sent and nothing is retired. During a halt, a force pulse drops the current identifier and loads the next one, even when matching is incomplete. Software sees the identifier under test, the most recently received identifier, the queue depth, the request number, the retry count and the per-channel matched bits.

Top module: `evmatch_ctrl`

## Requirements
- R1: After reset, `req_o`, `cur_valid_o`, `fifo_count_o`, `req_id_o`, `retry_cnt_o`, `matched_o` and `newest_id_o` are all zero.
- R2: Identifiers presented with `evt_valid_i` are queued in arrival order, up to DEPTH of them. A push into a full queue is dropped. `fifo_count_o` counts queued entries and excludes the identifier under test. `newest_id_o` shows the last identifier presented.
- R3: With no identifier under test and an empty queue, the block sends no request and `cur_valid_o` stays 0.
- R4: When the block is idle and not halted and the queue is not empty, it loads the queue head into `cur_id_o` and sets `cur_valid_o` on one clock edge. `req_o` is high for exactly the following cycle, with `req_id_o` giving the request number.
- R5: While matching is incomplete, request pulses repeat every `retry_tmo_i`+1 cycles (for `retry_tmo_i` >= 1). `retry_cnt_o` adds one for each request sent and saturates at its maximum.
- R6: An answer sets `matched_o[ch]` only when all of the following hold: `rpt_valid_i` is high, `rpt_ch_i` < NCH, `rpt_req_i` equals `req_id_o`, `rpt_id_i` equals `cur_id_o`, and an identifier is under test. Any other answer changes nothing.
- R7: `ch_disable_i[c]`=1 disables channel c and `ch_disable_i[c]`=0 enables it. Once every enabled channel is matched and the block is not halted, it retires the identifier on one edge. On that edge `cur_valid_o` and all matched bits clear, `req_id_o` adds one and `retry_cnt_o` returns to 0. The next queued identifier is then loaded.
- R8: While `halt_i` is 1, no request pulse is issued from the cycle after `halt_i` is seen. No identifier is retired, even when all channels are matched. Answers are still recorded.
- R9: A `force_i` pulse during a halt retires the identifier under test (matched bits clear, `req_id_o`+1, `retry_cnt_o`=0) if there is one. It also loads the queue head if the queue is not empty. Outside a halt, `force_i` is ignored.
- R10: When `halt_i` falls, the block sends a request in the next cycle if an identifier is under test. Otherwise it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | New identifier from trigger system |
| evt_id_i | input | ID_W | Identifier value |
| rpt_valid_i | input | 1 | Channel answer valid |
| rpt_ch_i | input | CH_W | Answering channel number |
| rpt_req_i | input | REQ_W | Request number being answered |
| rpt_id_i | input | ID_W | Identifier reported by the channel |
| ch_disable_i | input | NCH | Per-channel disable, 1 = disabled |
| retry_tmo_i | input | TMO_W | Cycles between repeated requests, minus one |
| halt_i | input | 1 | Freeze the sequencer |
| force_i | input | 1 | Forced advance pulse, effective while halted |
| req_o | output | 1 | Request broadcast pulse |
| req_id_o | output | REQ_W | Current request number |
| cur_valid_o | output | 1 | An identifier is under test |
| cur_id_o | output | ID_W | Identifier under test |
| newest_id_o | output | ID_W | Most recently received identifier |
| fifo_count_o | output | CNT_W | Queued identifiers, excluding the one under test |
| retry_cnt_o | output | RTY_W | Requests sent for the current identifier |
| matched_o | output | NCH | Per-channel matched bits |

## Verification
The hardest state to reach is a full queue with an identifier under test and a halt in force, where force pulses both retire and load. The stimulus asserts the halt before the first identifier arrives, so nothing leaves the queue. It then pushes one identifier more than the queue holds. Next it applies two force pulses, the first with nothing under test and the second with an identifier loaded. A later phase lets every enabled channel answer during a halt, so that completion sits blocked until release. The final phase disables all channels so the remaining queue drains one identifier per few cycles, and a scoreboard compares each first request against the expected request number and identifier.

// File: rtl/evm_pkg.sv
package evm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HALT = 2'd3
  } evm_state_e;
endpackage

// File: rtl/evm_id_fifo.sv
module evm_id_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(count_o));
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o <= CNT_W'(DEPTH)));
endmodule

// File: rtl/evm_match_tracker.sv
module evm_match_tracker #(
  parameter int NCH   = 8,
  parameter int CH_W  = 4,
  parameter int ID_W  = 36,
  parameter int REQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cur_valid_i,
  input  logic [ID_W-1:0]  cur_id_i,
  input  logic [REQ_W-1:0] req_id_i,
  input  logic             rpt_valid_i,
  input  logic [CH_W-1:0]  rpt_ch_i,
  input  logic [REQ_W-1:0] rpt_req_i,
  input  logic [ID_W-1:0]  rpt_id_i,
  input  logic [NCH-1:0]   ch_disable_i,
  input  logic             clr_i,
  output logic [NCH-1:0]   matched_o,
  output logic             done_o
);
  logic rpt_ok;
  assign rpt_ok = rpt_valid_i & cur_valid_i & (rpt_req_i == req_id_i) & (rpt_id_i == cur_id_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, m_q;
    assign hit = rpt_ok && (rpt_ch_i == CH_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   m_q <= 1'b0;
      else if (clr_i) m_q <= 1'b0;
      else if (hit)  m_q <= 1'b1;
    end
    assign matched_o[c] = m_q;
  end

  assign done_o = cur_valid_i & (&(matched_o | ch_disable_i));

  assert_clear_on_retire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (matched_o == '0));
  assert_range_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i && (int'(rpt_ch_i) >= NCH) && !clr_i) |=> $stable(matched_o));
  assert_stale_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i && (rpt_req_i != req_id_i) && !clr_i) |=> $stable(matched_o));
endmodule

// File: rtl/evm_seq.sv
module evm_seq
  import evm_pkg::*;
#(
  parameter int ID_W  = 36,
  parameter int REQ_W = 8,
  parameter int TMO_W = 16,
  parameter int RTY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             empty_i,
  input  logic [ID_W-1:0]  head_i,
  input  logic             done_i,
  input  logic             halt_i,
  input  logic             force_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             pop_o,
  output logic             adv_o,
  output logic             req_o,
  output logic [REQ_W-1:0] req_id_o,
  output logic [RTY_W-1:0] retry_cnt_o,
  output logic             cur_valid_o,
  output logic [ID_W-1:0]  cur_id_o
);
  evm_state_e       state_q, state_d;
  logic [TMO_W-1:0] tmr_q, tmr_d;
  logic [TMO_W:0]   tmr_nxt;
  logic [REQ_W-1:0] req_id_q;
  logic [RTY_W-1:0] rty_q;
  logic             cur_valid_q;
  logic [ID_W-1:0]  cur_id_q;

  assign tmr_nxt = {1'b0, tmr_q} + {{TMO_W{1'b0}}, 1'b1};

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    pop_o   = 1'b0;
    adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (halt_i) state_d = ST_HALT;
        else if (!empty_i) begin
          pop_o   = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        tmr_d   = '0;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (halt_i) state_d = ST_HALT;
        else if (done_i) begin
          adv_o   = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_nxt >= {1'b0, tmo_i}) state_d = ST_REQ;
        else tmr_d = tmr_nxt[TMO_W-1:0];
      end
      ST_HALT: begin
        if (!halt_i) state_d = cur_valid_q ? ST_REQ : ST_IDLE;
        else if (force_i) begin
          adv_o = cur_valid_q;
          pop_o = ~empty_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tmr_q       <= '0;
      req_id_q    <= '0;
      rty_q       <= '0;
      cur_valid_q <= 1'b0;
      cur_id_q    <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      if (pop_o) begin
        cur_id_q    <= head_i;
        cur_valid_q <= 1'b1;
      end else if (adv_o) begin
        cur_valid_q <= 1'b0;
      end
      if (adv_o) begin
        req_id_q <= req_id_q + 1'b1;
        rty_q    <= '0;
      end else if (state_q == ST_REQ && rty_q != '1) begin
        rty_q <= rty_q + 1'b1;
      end
    end
  end

  assign req_o       = (state_q == ST_REQ);
  assign req_id_o    = req_id_q;
  assign retry_cnt_o = rty_q;
  assign cur_valid_o = cur_valid_q;
  assign cur_id_o    = cur_id_q;

  assert_halt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !req_o);
  assert_retire_counters_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> (retry_cnt_o == '0) && (req_id_o == REQ_W'($past(req_id_o) + 1'b1)));
  assert_req_needs_id_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cur_valid_o);
  assert_req_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  assert_force_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !halt_i && !done_i) |=> $stable(req_id_o));
endmodule

// File: rtl/evmatch_ctrl.sv
module evmatch_ctrl #(
  parameter int ID_W  = 36,
  parameter int NCH   = 8,
  parameter int CH_W  = 4,
  parameter int DEPTH = 8,
  parameter int REQ_W = 8,
  parameter int TMO_W = 16,
  parameter int RTY_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [ID_W-1:0]  evt_id_i,
  input  logic             rpt_valid_i,
  input  logic [CH_W-1:0]  rpt_ch_i,
  input  logic [REQ_W-1:0] rpt_req_i,
  input  logic [ID_W-1:0]  rpt_id_i,
  input  logic [NCH-1:0]   ch_disable_i,
  input  logic [TMO_W-1:0] retry_tmo_i,
  input  logic             halt_i,
  input  logic             force_i,
  output logic             req_o,
  output logic [REQ_W-1:0] req_id_o,
  output logic             cur_valid_o,
  output logic [ID_W-1:0]  cur_id_o,
  output logic [ID_W-1:0]  newest_id_o,
  output logic [CNT_W-1:0] fifo_count_o,
  output logic [RTY_W-1:0] retry_cnt_o,
  output logic [NCH-1:0]   matched_o
);
  logic            pop, adv, empty, full, done;
  logic [ID_W-1:0] head;
  logic [ID_W-1:0] newest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          newest_q <= '0;
    else if (evt_valid_i) newest_q <= evt_id_i;
  end
  assign newest_id_o = newest_q;

  evm_id_fifo #(.W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (evt_valid_i),
    .data_i (evt_id_i),
    .pop_i  (pop),
    .head_o (head),
    .empty_o(empty),
    .full_o (full),
    .count_o(fifo_count_o)
  );

  evm_seq #(.ID_W(ID_W), .REQ_W(REQ_W), .TMO_W(TMO_W), .RTY_W(RTY_W)) u_seq (
    .clk_i, .rst_ni,
    .empty_i    (empty),
    .head_i     (head),
    .done_i     (done),
    .halt_i     (halt_i),
    .force_i    (force_i),
    .tmo_i      (retry_tmo_i),
    .pop_o      (pop),
    .adv_o      (adv),
    .req_o      (req_o),
    .req_id_o   (req_id_o),
    .retry_cnt_o(retry_cnt_o),
    .cur_valid_o(cur_valid_o),
    .cur_id_o   (cur_id_o)
  );

  evm_match_tracker #(.NCH(NCH), .CH_W(CH_W), .ID_W(ID_W), .REQ_W(REQ_W)) u_trk (
    .clk_i, .rst_ni,
    .cur_valid_i (cur_valid_o),
    .cur_id_i    (cur_id_o),
    .req_id_i    (req_id_o),
    .rpt_valid_i (rpt_valid_i),
    .rpt_ch_i    (rpt_ch_i),
    .rpt_req_i   (rpt_req_i),
    .rpt_id_i    (rpt_id_i),
    .ch_disable_i(ch_disable_i),
    .clr_i       (adv),
    .matched_o   (matched_o),
    .done_o      (done)
  );

  assert_idle_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_valid_o && fifo_count_o == '0 && !evt_valid_i) |=> !req_o);
  assert_full_no_pop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && halt_i && !force_i && !evt_valid_i) |=> full);
endmodule

// File: tb/sim_evmatch_ctrl.sv
module sim_evmatch_ctrl;
  localparam int ID_W = 36, NCH = 8, CH_W = 4, DEPTH = 8, REQ_W = 8, TMO_W = 16, RTY_W = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, rpt_valid = 0, halt = 0, force_p = 0;
  logic [ID_W-1:0]  evt_id = '0, rpt_id = '0;
  logic [CH_W-1:0]  rpt_ch = '0;
  logic [REQ_W-1:0] rpt_req = '0;
  logic [NCH-1:0]   dis = '0;
  logic [TMO_W-1:0] tmo = 16'd3;
  logic             req;
  logic [REQ_W-1:0] req_id;
  logic             cur_valid;
  logic [ID_W-1:0]  cur_id, newest;
  logic [CNT_W-1:0] cnt;
  logic [RTY_W-1:0] rty;
  logic [NCH-1:0]   matched;

  always #5 clk = ~clk;

  evmatch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_valid), .evt_id_i(evt_id),
    .rpt_valid_i(rpt_valid), .rpt_ch_i(rpt_ch), .rpt_req_i(rpt_req), .rpt_id_i(rpt_id),
    .ch_disable_i(dis), .retry_tmo_i(tmo), .halt_i(halt), .force_i(force_p),
    .req_o(req), .req_id_o(req_id), .cur_valid_o(cur_valid), .cur_id_o(cur_id),
    .newest_id_o(newest), .fifo_count_o(cnt), .retry_cnt_o(rty), .matched_o(matched)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0, nreq = 0, t_last = 0, t_prev = 0;
  bit finished = 0;
  logic [REQ_W+ID_W-1:0] exp_q[$];

  function automatic logic [ID_W-1:0] mk_id(int k);
    return {4'(k), 16'(16'hA000 + k), 16'(16'h5000 + k)};
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic answer(int ch, int rq, logic [ID_W-1:0] id);
    rpt_valid = 1; rpt_ch = CH_W'(ch); rpt_req = REQ_W'(rq); rpt_id = id;
    step(1);
    rpt_valid = 0;
  endtask

  task automatic pulse_force();
    force_p = 1; step(1); force_p = 0;
  endtask

  task automatic expect_req(int rq, logic [ID_W-1:0] id);
    exp_q.push_back({REQ_W'(rq), id});
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor: first request of each identifier
  always @(negedge clk) begin
    if (rst_n && req) begin
      nreq++;
      t_prev = t_last;
      t_last = cyc;
      if (rty == '0) begin
        n_run++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R4: unexpected request actual %0h_%0h expected none", req_id, cur_id);
        end else begin
          logic [REQ_W+ID_W-1:0] e;
          e = exp_q.pop_front();
          if ({req_id, cur_id} !== e) begin
            n_fail++;
            $display("FAIL R4/R2: request actual %0h_%0h expected %0h", req_id, cur_id, e);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n0;
    step(2);
    chk("R1 req", req, 0); chk("R1 cur_valid", cur_valid, 0); chk("R1 count", cnt, 0);
    chk("R1 req_id", req_id, 0); chk("R1 retry", rty, 0); chk("R1 matched", matched, 0);
    chk("R1 newest", newest, 0);
    rst_n = 1;
    step(10);
    chk("R3 idle no req", nreq, 0); chk("R3 cur_valid", cur_valid, 0);

    // fill queue while halted, one beyond capacity
    halt = 1; step(2);
    for (int k = 1; k <= DEPTH + 1; k++) begin
      evt_valid = 1; evt_id = mk_id(k); step(1);
    end
    evt_valid = 0; step(1);
    chk("R2 full count", cnt, DEPTH);
    chk("R2 newest", newest, mk_id(DEPTH + 1));
    chk("R8 halted no load", cur_valid, 0);

    // force with nothing under test: load only
    pulse_force();
    chk("R9 load id", cur_id, mk_id(1)); chk("R9 cur_valid", cur_valid, 1);
    chk("R9 req_id kept", req_id, 0); chk("R2 count after pop", cnt, DEPTH - 1);
    // force with identifier under test: retire and load
    pulse_force();
    chk("R9 retire req_id", req_id, 1); chk("R9 next id", cur_id, mk_id(2));
    chk("R9 count", cnt, DEPTH - 2);

    // release: periodic requests, channels 6 and 7 disabled
    expect_req(1, mk_id(2));
    dis = 8'hC0; tmo = 16'd3; halt = 0;
    step(14);
    chk("R10 resumed", (nreq >= 3), 1);
    chk("R5 spacing", t_last - t_prev, 4);
    chk("R5 retry count", rty, RTY_W'(nreq - (req ? 1 : 0)));

    // answer filtering
    answer(0, 0, mk_id(2));  step(1); chk("R6 stale req", matched, 0);
    answer(0, 1, mk_id(3));  step(1); chk("R6 wrong id", matched, 0);
    answer(9, 1, mk_id(2));  step(1); chk("R6 channel range", matched, 0);
    answer(0, 1, mk_id(2));  chk("R6 accepted", matched, 8'h01);
    for (int c = 1; c <= 4; c++) answer(c, 1, mk_id(2));
    chk("R7 partial no retire", req_id, 1); chk("R6 bits", matched, 8'h1F);
    expect_req(2, mk_id(3));
    answer(5, 1, mk_id(2));
    for (int i = 0; i < 6 && req_id == 1; i++) step(1);
    chk("R7 req_id", req_id, 2); chk("R7 cur cleared", cur_valid, 0);
    chk("R7 matched cleared", matched, 0); chk("R7 retry reset", rty, 0);
    step(2);
    chk("R7 next loaded", cur_id, mk_id(3)); chk("R2 count", cnt, DEPTH - 3);

    // halt while matching; answers still recorded, no retire
    halt = 1; step(3);
    n0 = nreq;
    for (int c = 0; c <= 5; c++) answer(c, 2, mk_id(3));
    step(10);
    chk("R8 no requests", nreq, n0); chk("R8 no retire", req_id, 2);
    chk("R8 recorded", matched, 8'h3F);
    expect_req(3, mk_id(4));
    halt = 0; n0 = nreq;
    step(2);
    chk("R10 request after release", nreq, n0 + 1);
    step(5);
    chk("R7 after release", req_id, 3); chk("R7 loaded", cur_id, mk_id(4));
    chk("R2 count4", cnt, DEPTH - 4);

    // force outside halt is ignored
    tmo = 16'd50;
    answer(0, 3, mk_id(4));
    pulse_force();
    chk("R9 ignored req_id", req_id, 3); chk("R9 ignored matched", matched, 8'h01);
    chk("R9 ignored cur", cur_id, mk_id(4));

    // all channels disabled: queue drains in order
    for (int k = 5; k <= DEPTH; k++) expect_req(k - 1, mk_id(k));
    dis = 8'hFF;
    step(40);
    chk("R2 drained order", exp_q.size(), 0);
    chk("R7 final req_id", req_id, DEPTH);
    chk("R3 idle cur", cur_valid, 0); chk("R3 count", cnt, 0);
    n0 = nreq; step(20);
    chk("R3 no requests", nreq, n0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule